// File: doc/BRIEF.md
# Software Nonvolatile Command Sequence Detector

This block sits on the bus of a byte-wide SRAM with a 13-bit address space. It serves ordinary reads and writes from a behavioural array. It also watches for a fixed chain of six read cycles, each at a set address. When the chain completes, the block raises a one-cycle request to a nonvolatile engine. The final address of the chain picks the request: either a copy of the SRAM into nonvolatile cells (store) or a copy back (recall). The chain is only recognised when the reads come in exact order and no write comes between them. The output enable has no part in the decision.

The bus strobes arrive in a synchronous clock domain. A bus cycle counts once, on the clock where the sampled chip enable goes from high to low. The address and write enable are taken from that same sample. The engine is modelled as a counter that stays busy for `BUSY_CYC` clocks. While it is busy, the data outputs are not driven, incoming bus cycles are dropped, and the matcher is held at its first step. The behavioural array has `2**MEM_AW` bytes and is indexed by the low address bits, so higher addresses alias.

Top module: `nv_cmd_detect`

## Requirements
- R1: A bus cycle starts only on a clock where `ce_ni` is sampled low after having been sampled high. `addr_i`, `we_ni` and `wdata_i` are captured at that clock, and address changes later in the same low period have no effect.
- R2: A read cycle (`we_ni` high at start) puts the byte stored at `addr_i[MEM_AW-1:0]` on `rdata_o` one clock after the start. `rdata_oe_o` is 1 only while `ce_ni` is low, `oe_ni` is low, `we_ni` is high and the engine is idle.
- R3: A write cycle (`we_ni` low at start) stores `wdata_i` at `addr_i[MEM_AW-1:0]`.
- R4: Six consecutive read cycles at hex 0000, 1555, 0AAA, 1FFF, 10F0, 0F0F give a single one-clock pulse on `store_req_o`, in the clock after the sixth cycle starts.
- R5: The same first five reads followed by a read at 0F0E give a single one-clock pulse on `recall_req_o`, with the same timing as R4.
- R6: A read at an address out of order restarts the matcher. If that address is 0000 it counts as the first step of a new chain. A sixth address other than 0F0F or 0F0E issues no request.
- R7: A write cycle anywhere in the chain cancels it, and no request follows the remaining reads.
- R8: Recognition does not depend on `oe_ni`; a chain read with `oe_ni` high still issues its request.
- R9: After a request, `nv_busy_o` is high for exactly `BUSY_CYC` clocks, starting in the same clock as the pulse. Store and recall requests are never high together.
- R10: While `nv_busy_o` is high, bus cycles are ignored (writes do not store, reads do not advance the matcher), `rdata_oe_o` stays 0, and the matcher is reset to its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 13 | Bus address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| rdata_oe_o | output | 1 | Drive enable for the data bus; 0 means high impedance |
| store_req_o | output | 1 | One-clock store request to the nonvolatile engine |
| recall_req_o | output | 1 | One-clock recall request to the nonvolatile engine |
| nv_busy_o | output | 1 | Nonvolatile engine busy |

## Verification
The assertions check the following on every cycle:
- a request is a single-clock pulse;
- the two requests exclude each other;
- busy is up whenever a request is;
- no request appears after a busy clock;
- the data bus is never driven while busy or outside a read with both enables low;
- every request traces back to a read cycle start at its tail address.

The rest needs the bench's scenarios:
- the order of the six addresses;
- the restart at 0000;
- cancellation by a write;
- indifference to the output enable;
- the length of the busy window;
- cycles dropped during busy;
- a bus cycle counted once however long chip enable stays low.

// File: rtl/nv_cmd_pkg.sv
package nv_cmd_pkg;
  localparam int unsigned BUS_AW  = 13;
  localparam int unsigned SEQ_LEN = 6;
  localparam int unsigned STEP_W  = $clog2(SEQ_LEN);

  typedef logic [BUS_AW-1:0] bus_addr_t;
  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    NV_NONE   = 2'd0,
    NV_STORE  = 2'd1,
    NV_RECALL = 2'd2
  } nv_cmd_e;

  localparam bus_addr_t STORE_TAIL  = 13'h0F0F;
  localparam bus_addr_t RECALL_TAIL = 13'h0F0E;

  // expected address for steps 0..SEQ_LEN-2; the last step is decoded apart
  function automatic bus_addr_t seq_addr(input step_t idx);
    case (idx)
      step_t'(0): seq_addr = 13'h0000;
      step_t'(1): seq_addr = 13'h1555;
      step_t'(2): seq_addr = 13'h0AAA;
      step_t'(3): seq_addr = 13'h1FFF;
      step_t'(4): seq_addr = 13'h10F0;
      default:    seq_addr = 13'h0000;
    endcase
  endfunction
endpackage

// File: rtl/nv_cycle_detect.sv
module nv_cycle_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic busy_i,
  output logic rd_start_o,
  output logic wr_start_o
);
  logic ce_q;
  logic start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b1;
    else         ce_q <= ce_ni;
  end

  // falling chip enable opens exactly one cycle; dropped while busy
  assign start      = ce_q & ~ce_ni & ~busy_i;
  assign rd_start_o = start & we_ni;
  assign wr_start_o = start & ~we_ni;
endmodule

// File: rtl/nv_seq_matcher.sv
module nv_seq_matcher
  import nv_cmd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rd_start_i,
  input  logic      wr_start_i,
  input  logic      busy_i,
  input  bus_addr_t addr_i,
  output nv_cmd_e   hit_o,
  output logic      store_req_o,
  output logic      recall_req_o
);
  step_t   step_q, step_d;
  nv_cmd_e hit;
  logic    restart;

  assign restart = (addr_i == seq_addr(step_t'(0)));

  always_comb begin
    step_d = step_q;
    hit    = NV_NONE;
    if (busy_i || wr_start_i) begin
      step_d = step_t'(0);
    end else if (rd_start_i) begin
      if (step_q == step_t'(SEQ_LEN-1)) begin
        if (addr_i == STORE_TAIL)       hit = NV_STORE;
        else if (addr_i == RECALL_TAIL) hit = NV_RECALL;
        step_d = restart ? step_t'(1) : step_t'(0);
      end else if (addr_i == seq_addr(step_q)) begin
        step_d = step_q + step_t'(1);
      end else begin
        step_d = restart ? step_t'(1) : step_t'(0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q       <= step_t'(0);
      store_req_o  <= 1'b0;
      recall_req_o <= 1'b0;
    end else begin
      step_q       <= step_d;
      store_req_o  <= (hit == NV_STORE);
      recall_req_o <= (hit == NV_RECALL);
    end
  end

  assign hit_o = hit;
endmodule

// File: rtl/nv_sram_array.sv
module nv_sram_array #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/nv_busy_engine.sv
module nv_busy_engine #(
  parameter int unsigned BUSY_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nv_cmd_detect.sv
module nv_cmd_detect
  import nv_cmd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MEM_AW   = 8,
  parameter int unsigned BUSY_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [12:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              store_req_o,
  output logic              recall_req_o,
  output logic              nv_busy_o
);
  logic    rd_start, wr_start, busy;
  nv_cmd_e hit;

  nv_cycle_detect i_cycle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .busy_i    (busy),
    .rd_start_o(rd_start),
    .wr_start_o(wr_start)
  );

  nv_seq_matcher i_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_start_i  (rd_start),
    .wr_start_i  (wr_start),
    .busy_i      (busy),
    .addr_i      (addr_i),
    .hit_o       (hit),
    .store_req_o (store_req_o),
    .recall_req_o(recall_req_o)
  );

  nv_sram_array #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) i_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_start),
    .wr_en_i(wr_start),
    .addr_i (addr_i[MEM_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  nv_busy_engine #(.BUSY_CYC(BUSY_CYC)) i_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(hit != NV_NONE),
    .busy_o (busy)
  );

  assign nv_busy_o  = busy;
  assign rdata_oe_o = ~ce_ni & ~oe_ni & we_ni & ~busy;
endmodule

// File: rtl/nv_cmd_detect_chk.sv
module nv_cmd_detect_chk
  import nv_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [12:0]       addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              store_req_o,
  input logic              recall_req_o,
  input logic              nv_busy_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_req_o, recall_req_o})); // R9
  AST_STORE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o); // R4
  AST_RECALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o); // R5
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_o || recall_req_o) |-> nv_busy_o); // R9
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(nv_busy_o) |-> !(store_req_o || recall_req_o)); // R10
  AST_NO_DRIVE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_busy_o |-> !rdata_oe_o); // R10
  AST_DRIVE_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (!ce_ni && !oe_ni && we_ni)); // R2
  AST_STORE_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> $past(!ce_ni && we_ni && addr_i == STORE_TAIL)); // R4
  AST_RECALL_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |-> $past(!ce_ni && we_ni && addr_i == RECALL_TAIL)); // R5
endmodule

bind nv_cmd_detect nv_cmd_detect_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .we_ni       (we_ni),
  .oe_ni       (oe_ni),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .rdata_oe_o  (rdata_oe_o),
  .store_req_o (store_req_o),
  .recall_req_o(recall_req_o),
  .nv_busy_o   (nv_busy_o)
);

// File: tb/test_nv_cmd_detect.sv
`timescale 1ns/1ps
module test_nv_cmd_detect;
  localparam int unsigned BUSY_N = 40;
  localparam int unsigned NVEC   = 44;

  typedef struct packed {
    logic        wr;
    logic [12:0] addr;
    logic [7:0]  wd;
    logic [7:0]  exp;
    logic [1:0]  cmd;   // 0 none, 1 store, 2 recall
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    // fill array (R3)
    '{1'b1,13'h0000,8'h11,8'h00,2'd0}, '{1'b1,13'h1555,8'h22,8'h00,2'd0},
    '{1'b1,13'h0AAA,8'h33,8'h00,2'd0}, '{1'b1,13'h1FFF,8'h44,8'h00,2'd0},
    '{1'b1,13'h10F0,8'h55,8'h00,2'd0}, '{1'b1,13'h0F0F,8'h66,8'h00,2'd0},
    '{1'b1,13'h0F0E,8'h77,8'h00,2'd0},
    // store chain (R4)
    '{1'b0,13'h0000,8'h00,8'h11,2'd0}, '{1'b0,13'h1555,8'h00,8'h22,2'd0},
    '{1'b0,13'h0AAA,8'h00,8'h33,2'd0}, '{1'b0,13'h1FFF,8'h00,8'h44,2'd0},
    '{1'b0,13'h10F0,8'h00,8'h55,2'd0}, '{1'b0,13'h0F0F,8'h00,8'h66,2'd1},
    // recall chain (R5)
    '{1'b0,13'h0000,8'h00,8'h11,2'd0}, '{1'b0,13'h1555,8'h00,8'h22,2'd0},
    '{1'b0,13'h0AAA,8'h00,8'h33,2'd0}, '{1'b0,13'h1FFF,8'h00,8'h44,2'd0},
    '{1'b0,13'h10F0,8'h00,8'h55,2'd0}, '{1'b0,13'h0F0E,8'h00,8'h77,2'd2},
    // out of order (R6)
    '{1'b0,13'h0000,8'h00,8'h11,2'd0}, '{1'b0,13'h0AAA,8'h00,8'h33,2'd0},
    '{1'b0,13'h1FFF,8'h00,8'h44,2'd0}, '{1'b0,13'h10F0,8'h00,8'h55,2'd0},
    '{1'b0,13'h0F0F,8'h00,8'h66,2'd0},
    // write in the middle (R7)
    '{1'b0,13'h0000,8'h00,8'h11,2'd0}, '{1'b0,13'h1555,8'h00,8'h22,2'd0},
    '{1'b1,13'h0AAA,8'h33,8'h00,2'd0}, '{1'b0,13'h1FFF,8'h00,8'h44,2'd0},
    '{1'b0,13'h10F0,8'h00,8'h55,2'd0}, '{1'b0,13'h0F0F,8'h00,8'h66,2'd0},
    // restart at 0000 (R6)
    '{1'b0,13'h0000,8'h00,8'h11,2'd0}, '{1'b0,13'h1555,8'h00,8'h22,2'd0},
    '{1'b0,13'h0000,8'h00,8'h11,2'd0}, '{1'b0,13'h1555,8'h00,8'h22,2'd0},
    '{1'b0,13'h0AAA,8'h00,8'h33,2'd0}, '{1'b0,13'h1FFF,8'h00,8'h44,2'd0},
    '{1'b0,13'h10F0,8'h00,8'h55,2'd0}, '{1'b0,13'h0F0F,8'h00,8'h66,2'd1},
    // wrong sixth address (R6)
    '{1'b0,13'h0000,8'h00,8'h11,2'd0}, '{1'b0,13'h1555,8'h00,8'h22,2'd0},
    '{1'b0,13'h0AAA,8'h00,8'h33,2'd0}, '{1'b0,13'h1FFF,8'h00,8'h44,2'd0},
    '{1'b0,13'h10F0,8'h00,8'h55,2'd0}, '{1'b0,13'h10F0,8'h00,8'h55,2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe, store_req, recall_req, busy;

  int n_chk = 0, n_fail = 0;
  int n_store = 0, n_recall = 0, run = 0, last_run = 0, wd = 0;
  logic       last_oe;
  logic [7:0] last_rd;

  always #2.5 clk = ~clk;

  nv_cmd_detect #(.DATA_W(8), .MEM_AW(8), .BUSY_CYC(BUSY_N)) i_nv_cmd_detect (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .store_req_o(store_req), .recall_req_o(recall_req), .nv_busy_o(busy)
  );

  always @(negedge clk) begin
    if (store_req)  n_store++;
    if (recall_req) n_recall++;
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic wr, input logic [12:0] a, input logic [7:0] d,
                           input logic oe_lo, input int hold);
    @(negedge clk);
    addr = a; we_n = ~wr; wdata = d; oe_n = ~oe_lo; ce_n = 1'b0;
    repeat (hold) @(negedge clk);
    last_oe = rdata_oe; last_rd = rdata;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_of(input int i);
    if (i < 7)       return "R3";
    else if (i < 13) return "R4";
    else if (i < 19) return "R5";
    else if (i < 24) return "R6";
    else if (i < 30) return "R7";
    else             return "R6";
  endfunction

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R9 reset busy", busy, 0);
    chk("R4 reset store", store_req, 0);
    chk("R5 reset recall", recall_req, 0);
    chk("R2 reset drive", rdata_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      s0 = n_store; r0 = n_recall;
      bus_cycle(VECS[i].wr, VECS[i].addr, VECS[i].wd, 1'b1, 3);
      if (!VECS[i].wr && VECS[i].cmd == 2'd0) begin
        chk("R2 read data", last_rd, VECS[i].exp);
        chk("R2 drive", last_oe, 1);
      end
      wait_idle();
      chk({tag_of(i), " store count"}, n_store - s0, (VECS[i].cmd == 2'd1) ? 1 : 0);
      chk({tag_of(i), " recall count"}, n_recall - r0, (VECS[i].cmd == 2'd2) ? 1 : 0);
    end

    // R8: output enable high throughout, store still issued, bus undriven
    s0 = n_store;
    bus_cycle(1'b0, 13'h0000, 8'h00, 1'b0, 3); chk("R8 no drive", last_oe, 0);
    bus_cycle(1'b0, 13'h1555, 8'h00, 1'b0, 3);
    bus_cycle(1'b0, 13'h0AAA, 8'h00, 1'b0, 3);
    bus_cycle(1'b0, 13'h1FFF, 8'h00, 1'b0, 3);
    bus_cycle(1'b0, 13'h10F0, 8'h00, 1'b0, 3);
    bus_cycle(1'b0, 13'h0F0F, 8'h00, 1'b0, 3);
    chk("R8 store despite oe high", n_store - s0, 1);
    chk("R8 read data oe high", last_rd, 8'h66);

    // R10: cycles during busy are dropped; R9 busy length
    chk("R10 busy after request", busy, 1);
    bus_cycle(1'b1, 13'h0000, 8'h99, 1'b1, 3);
    bus_cycle(1'b0, 13'h0000, 8'h00, 1'b1, 3);
    chk("R10 no drive while busy", last_oe, 0);
    bus_cycle(1'b0, 13'h1555, 8'h00, 1'b1, 3);
    bus_cycle(1'b0, 13'h0AAA, 8'h00, 1'b1, 3);
    wait_idle();
    chk("R9 busy length", last_run, BUSY_N);
    s0 = n_store;
    bus_cycle(1'b0, 13'h1FFF, 8'h00, 1'b1, 3);
    bus_cycle(1'b0, 13'h10F0, 8'h00, 1'b1, 3);
    bus_cycle(1'b0, 13'h0F0F, 8'h00, 1'b1, 3);
    chk("R10 matcher reset by busy", n_store - s0, 0);
    bus_cycle(1'b0, 13'h0000, 8'h00, 1'b1, 3);
    chk("R10 write ignored while busy", last_rd, 8'h11);

    // R1: address change inside one low period counts once
    s0 = n_store;
    @(negedge clk); addr = 13'h0000; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = 13'h1555;
    repeat (3) @(negedge clk);
    chk("R1 data from start address", rdata, 8'h11);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_cycle(1'b0, 13'h0AAA, 8'h00, 1'b1, 3);
    bus_cycle(1'b0, 13'h1FFF, 8'h00, 1'b1, 3);
    bus_cycle(1'b0, 13'h10F0, 8'h00, 1'b1, 3);
    bus_cycle(1'b0, 13'h0F0F, 8'h00, 1'b1, 3);
    chk("R1 mid-cycle address not counted", n_store - s0, 0);

    // R1: long low periods each count once
    r0 = n_recall;
    bus_cycle(1'b0, 13'h0000, 8'h00, 1'b1, 12);
    bus_cycle(1'b0, 13'h1555, 8'h00, 1'b1, 12);
    bus_cycle(1'b0, 13'h0AAA, 8'h00, 1'b1, 12);
    bus_cycle(1'b0, 13'h1FFF, 8'h00, 1'b1, 12);
    bus_cycle(1'b0, 13'h10F0, 8'h00, 1'b1, 12);
    bus_cycle(1'b0, 13'h0F0E, 8'h00, 1'b1, 12);
    chk("R1 long cycles recall", n_recall - r0, 1);
    wait_idle();

    // R2: aliasing on low address bits
    bus_cycle(1'b0, 13'h0100, 8'h00, 1'b1, 3);
    chk("R2 aliased read", last_rd, 8'h11);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule